// File: doc/BRIEF.md
# DMA Engine Lifecycle Controller

This block sequences a send DMA engine through bring-up, normal running, halting, a two-phase clean-up and shutdown. Software and hardware report what has happened as one-cycle event pulses, each carrying a 4-bit event code. The controller keeps one of seven states and a sticky "run requested" flag. From these it drives level control outputs for the engine: enable, interrupt enable, halt and drain.

On some transitions it also fires a one-cycle action strobe. The strobes are start software clean-up, start hardware clean-up, start hardware start-up and tear down. The work behind each strobe is done elsewhere, and completion comes back as a later event. A run request that arrives while the engine is stopping or restarting is kept. It is honoured once hardware start-up completes.

Two error-halt events are handled differently. Type A goes straight to software clean-up. Type B first waits for the halt to complete and then runs hardware clean-up. The controller also records the last event code seen and the state it left on its most recent state change.

Top module: `dma_life_fsm`

## Requirements
- R1: While reset is asserted, and directly after it is released, the state is hw-down (code 0), the run flag is 0, last_event and prev_state are 0, and every control output, status output and strobe is 0.
- R2: In hw-down (0), go-start (event 1) moves to start-up wait (1) and leaves the run flag unchanged. Go-running (3) also moves to start-up wait and sets the run flag. In start-up wait, hw-started (2) moves to running (6) if the run flag is 1, and to idle (2) if it is 0.
- R3: In idle (2), go-running (3) moves to running (6) and sets the run flag.
- R4: In running (6), hw-halted (6) moves to sw-clean-up wait (3) and pulses act_sw_clean. Error-halt A (8) does the same. Error-halt B (9) moves to halt wait (5) with no strobe. Go-idle (7) moves to halt wait and clears the run flag.
- R5: In halt wait (5), hw-halted (6) moves to hw-clean-up wait (4) and pulses act_hw_clean. In hw-clean-up wait, hw-cleaned (5) moves to sw-clean-up wait (3) and pulses act_sw_clean. In sw-clean-up wait, sw-cleaned (4) moves to start-up wait (1) and pulses act_hw_start.
- R6: Go-down (0) moves to hw-down. From start-up wait or idle it pulses act_teardown. From halt wait, hw-clean-up wait or running it pulses act_sw_clean. From sw-clean-up wait it pulses no strobe. In hw-down, go-down has no effect, and sw-cleaned (4) pulses act_teardown with no state change.
- R7: In start-up wait, sw-clean-up wait, hw-clean-up wait and halt wait, go-running (3) sets the run flag and go-idle (7) clears it, and the state does not change.
- R8: ctl_enable, ctl_intr_en and is_running are 1 only in running. ctl_halt is 1 in halt wait, hw-clean-up wait and sw-clean-up wait. ctl_drain is 1 only in halt wait.
- R9: The timer tick (10), codes 11 to 15, and any event with no rule above for the current state leave the state and the run flag unchanged and fire no strobe. Every strobe lasts exactly one cycle, in the cycle after the accepted event.
- R10: Each accepted event is written to last_event in the following cycle. On each state change, prev_state takes the state that was left. All changes appear one clock after the event is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event pulse, one cycle per event |
| ev_code | input | EVW (4) | Event code |
| state | output | 3 | Current state code |
| prev_state | output | 3 | State left on the last state change |
| last_event | output | EVW (4) | Last accepted event code |
| run_req | output | 1 | Sticky run-requested flag |
| is_running | output | 1 | High in the running state |
| ctl_enable | output | 1 | Engine enable |
| ctl_intr_en | output | 1 | Engine interrupt enable |
| ctl_halt | output | 1 | Engine halt request |
| ctl_drain | output | 1 | Engine drain request |
| act_sw_clean | output | 1 | Strobe: start software clean-up |
| act_hw_clean | output | 1 | Strobe: start hardware clean-up |
| act_hw_start | output | 1 | Strobe: start hardware start-up |
| act_teardown | output | 1 | Strobe: tear down |

## Verification
The bench builds the block with the default EVW of 4. This lets it drive every one of the 16 event codes, including the five codes that have no meaning, in every one of the seven states. Random event streams with gaps between events walk the halt, clean-up and restart loops many times, both with the run flag set and with it cleared. Directed sequences pin down the two error-halt paths, the three forms of go-down and the run request that survives a restart.

// File: rtl/dma_life_fsm.sv
module dma_life_fsm #(
  parameter int EVW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_valid,
  input  logic [EVW-1:0] ev_code,
  output logic [2:0]     state,
  output logic [2:0]     prev_state,
  output logic [EVW-1:0] last_event,
  output logic           run_req,
  output logic           is_running,
  output logic           ctl_enable,
  output logic           ctl_intr_en,
  output logic           ctl_halt,
  output logic           ctl_drain,
  output logic           act_sw_clean,
  output logic           act_hw_clean,
  output logic           act_hw_start,
  output logic           act_teardown
);
  localparam logic [2:0] S_DOWN = 3'd0, S_START = 3'd1, S_IDLE = 3'd2,
                         S_SWCL = 3'd3, S_HWCL = 3'd4, S_HALT = 3'd5, S_RUN = 3'd6;
  localparam logic [EVW-1:0] E_DOWN = EVW'(0), E_START = EVW'(1), E_STARTED = EVW'(2),
                             E_RUN = EVW'(3), E_SWDONE = EVW'(4), E_HWDONE = EVW'(5),
                             E_HALTED = EVW'(6), E_IDLE = EVW'(7), E_ERRA = EVW'(8),
                             E_ERRB = EVW'(9);

  logic [2:0] nxt;
  logic       nrun, s_sw, s_hw, s_up, s_td;

  always_comb begin
    nxt  = state;
    nrun = run_req;
    s_sw = 1'b0;
    s_hw = 1'b0;
    s_up = 1'b0;
    s_td = 1'b0;
    if (ev_valid) begin
      case (state)
        S_DOWN: begin
          if (ev_code == E_START) nxt = S_START;
          if (ev_code == E_RUN) begin nxt = S_START; nrun = 1'b1; end
          if (ev_code == E_SWDONE) s_td = 1'b1;
        end
        S_START: begin
          if (ev_code == E_STARTED) nxt = run_req ? S_RUN : S_IDLE;
          if (ev_code == E_DOWN) begin nxt = S_DOWN; s_td = 1'b1; end
        end
        S_IDLE: begin
          if (ev_code == E_RUN) begin nxt = S_RUN; nrun = 1'b1; end
          if (ev_code == E_DOWN) begin nxt = S_DOWN; s_td = 1'b1; end
        end
        S_SWCL: begin
          if (ev_code == E_SWDONE) begin nxt = S_START; s_up = 1'b1; end
          if (ev_code == E_DOWN) nxt = S_DOWN;
        end
        S_HWCL: begin
          if (ev_code == E_HWDONE) begin nxt = S_SWCL; s_sw = 1'b1; end
          if (ev_code == E_DOWN) begin nxt = S_DOWN; s_sw = 1'b1; end
        end
        S_HALT: begin
          if (ev_code == E_HALTED) begin nxt = S_HWCL; s_hw = 1'b1; end
          if (ev_code == E_DOWN) begin nxt = S_DOWN; s_sw = 1'b1; end
        end
        S_RUN: begin
          if (ev_code == E_HALTED || ev_code == E_ERRA) begin nxt = S_SWCL; s_sw = 1'b1; end
          if (ev_code == E_ERRB) nxt = S_HALT;
          if (ev_code == E_IDLE) begin nxt = S_HALT; nrun = 1'b0; end
          if (ev_code == E_DOWN) begin nxt = S_DOWN; s_sw = 1'b1; end
        end
        default: nxt = S_DOWN;
      endcase
      if (state == S_START || state == S_SWCL || state == S_HWCL || state == S_HALT) begin
        if (ev_code == E_RUN)  nrun = 1'b1;
        if (ev_code == E_IDLE) nrun = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_DOWN;
      prev_state   <= S_DOWN;
      last_event   <= '0;
      run_req      <= 1'b0;
      act_sw_clean <= 1'b0;
      act_hw_clean <= 1'b0;
      act_hw_start <= 1'b0;
      act_teardown <= 1'b0;
    end else begin
      state        <= nxt;
      run_req      <= nrun;
      act_sw_clean <= s_sw;
      act_hw_clean <= s_hw;
      act_hw_start <= s_up;
      act_teardown <= s_td;
      if (ev_valid) last_event <= ev_code;
      if (nxt != state) prev_state <= state;
    end
  end

  assign is_running  = (state == S_RUN);
  assign ctl_enable  = is_running;
  assign ctl_intr_en = is_running;
  assign ctl_halt    = (state == S_HALT) || (state == S_HWCL) || (state == S_SWCL);
  assign ctl_drain   = (state == S_HALT);
endmodule

module dma_life_fsm_chk #(
  parameter int EVW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ev_valid,
  input logic [EVW-1:0] ev_code,
  input logic [2:0]     state,
  input logic           run_req,
  input logic           ctl_enable,
  input logic           ctl_halt,
  input logic           act_sw_clean,
  input logic           act_hw_clean,
  input logic           act_hw_start,
  input logic           act_teardown
);
  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_sw_clean, act_hw_clean, act_hw_start, act_teardown}));
  assert_teardown_in_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_teardown |-> state == 3'd0);
  assert_hwstart_in_startwait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_hw_start |-> state == 3'd1);
  assert_hwclean_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_hw_clean |-> state == 3'd4);
  assert_swclean_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_sw_clean |-> (state == 3'd3 || state == 3'd0));
  assert_enable_not_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_enable |-> !ctl_halt);
  assert_tick_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == EVW'(10)) |=> ($stable(state) && $stable(run_req)));
  assert_no_event_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> ($stable(state) && !act_sw_clean && !act_teardown));
endmodule

bind dma_life_fsm dma_life_fsm_chk #(.EVW(EVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
  .state(state), .run_req(run_req), .ctl_enable(ctl_enable), .ctl_halt(ctl_halt),
  .act_sw_clean(act_sw_clean), .act_hw_clean(act_hw_clean),
  .act_hw_start(act_hw_start), .act_teardown(act_teardown)
);

// File: tb/test_dma_life_fsm.sv
module test_dma_life_fsm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [3:0] ev_code = 4'd0;
  logic [2:0] state, prev_state;
  logic [3:0] last_event;
  logic run_req, is_running, ctl_enable, ctl_intr_en, ctl_halt, ctl_drain;
  logic act_sw_clean, act_hw_clean, act_hw_start, act_teardown;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [2:0] m_state = 0, m_prev = 0;
  logic [3:0] m_last = 0;
  logic m_run = 0, m_sw = 0, m_hw = 0, m_up = 0, m_td = 0;
  string m_tag = "R1";

  always #10 clk = ~clk;

  dma_life_fsm i_dma_life_fsm (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .state(state), .prev_state(prev_state), .last_event(last_event),
    .run_req(run_req), .is_running(is_running), .ctl_enable(ctl_enable),
    .ctl_intr_en(ctl_intr_en), .ctl_halt(ctl_halt), .ctl_drain(ctl_drain),
    .act_sw_clean(act_sw_clean), .act_hw_clean(act_hw_clean),
    .act_hw_start(act_hw_start), .act_teardown(act_teardown)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk(m_tag, "state", state, m_state);
    chk(m_tag, "run_req", run_req, m_run);
    chk(m_tag, "act_sw_clean", act_sw_clean, m_sw);
    chk(m_tag, "act_hw_clean", act_hw_clean, m_hw);
    chk(m_tag, "act_hw_start", act_hw_start, m_up);
    chk(m_tag, "act_teardown", act_teardown, m_td);
    chk("R8", "is_running", is_running, m_state == 6);
    chk("R8", "ctl_enable", ctl_enable, m_state == 6);
    chk("R8", "ctl_intr_en", ctl_intr_en, m_state == 6);
    chk("R8", "ctl_halt", ctl_halt, m_state == 3 || m_state == 4 || m_state == 5);
    chk("R8", "ctl_drain", ctl_drain, m_state == 5);
    chk("R10", "last_event", last_event, m_last);
    chk("R10", "prev_state", prev_state, m_prev);
  endtask

  task automatic model(input logic v, input logic [3:0] e);
    logic [2:0] n;
    logic r;
    n = m_state; r = m_run;
    m_sw = 0; m_hw = 0; m_up = 0; m_td = 0;
    m_tag = "R9";
    if (v) begin
      if (e == 0 && m_state != 0) begin
        n = 0; m_tag = "R6";
        if (m_state == 1 || m_state == 2) m_td = 1;
        if (m_state == 4 || m_state == 5 || m_state == 6) m_sw = 1;
      end
      case (m_state)
        0: begin
          if (e == 1) begin n = 1; m_tag = "R2"; end
          if (e == 3) begin n = 1; r = 1; m_tag = "R2"; end
          if (e == 4) begin m_td = 1; m_tag = "R6"; end
        end
        1: if (e == 2) begin n = m_run ? 3'd6 : 3'd2; m_tag = "R2"; end
        2: if (e == 3) begin n = 6; r = 1; m_tag = "R3"; end
        3: if (e == 4) begin n = 1; m_up = 1; m_tag = "R5"; end
        4: if (e == 5) begin n = 3; m_sw = 1; m_tag = "R5"; end
        5: if (e == 6) begin n = 4; m_hw = 1; m_tag = "R5"; end
        6: begin
          if (e == 6 || e == 8) begin n = 3; m_sw = 1; m_tag = "R4"; end
          if (e == 9) begin n = 5; m_tag = "R4"; end
          if (e == 7) begin n = 5; r = 0; m_tag = "R4"; end
        end
        default: ;
      endcase
      if (m_state == 1 || m_state == 3 || m_state == 4 || m_state == 5) begin
        if (e == 3) begin r = 1; m_tag = "R7"; end
        if (e == 7) begin r = 0; m_tag = "R7"; end
      end
      m_last = e;
      if (n != m_state) m_prev = m_state;
    end
    m_state = n; m_run = r;
  endtask

  task automatic step(input logic v, input logic [3:0] e);
    ev_valid = v; ev_code = e;
    model(v, e);
    @(negedge clk);
    check_all();
  endtask

  task automatic ev(input logic [3:0] e);
    step(1'b1, e);
    step(1'b0, 4'd0);
  endtask

  initial begin
    @(negedge clk);
    m_tag = "R1";
    check_all();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_tag = "R1";
    check_all();
    // R2 bring-up into idle, R3 idle to running
    ev(1); ev(2); ev(3);
    // R4 error-halt A path, R5 restart keeps run flag, R2 hw-started to running
    ev(8); ev(4); ev(2);
    // R4 error-halt B path, R5 full clean-up chain
    ev(9); ev(6); ev(5); ev(4);
    // R7 go-idle in start-up wait clears flag, then hw-started lands in idle
    ev(7); ev(2);
    // R6 go-down from idle tears down; sw-cleaned in hw-down tears down
    ev(0); ev(4); ev(0);
    // R2 go-running from hw-down sets flag; R9 tick and unused codes
    ev(3); ev(10); ev(13); ev(2);
    // R4 go-idle from running, R6 go-down from halt wait
    ev(7); ev(0);
    // R6 go-down from sw-clean-up wait has no strobe
    ev(3); ev(2); ev(6); ev(0);
    // back-to-back events
    step(1'b1, 4'd3); step(1'b1, 4'd2); step(1'b1, 4'd6); step(1'b1, 4'd4); step(1'b0, 4'd0);
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] e;
      int p;
      p = $urandom_range(0, 99);
      if (p < 12) e = 4'd0;
      else if (p < 20) e = 4'(10 + $urandom_range(0, 5));
      else e = 4'($urandom_range(1, 9));
      step($urandom_range(0, 9) < 7, e);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule